// File: doc/BRIEF.md
# Dual-Plane Flash Program Sequencer

This block runs the host-side script for a two-page program of a register-mapped NAND flash device. A one-cycle `start` pulse captures the target block, page, die select and interrupt-mode choice. The sequencer first checks that the block number is even. It then writes the addressing registers and selects the die's buffer. Next it streams one page of words from a valid/ready source into the device buffer RAM and configures the buffer window. It clears the interrupt register, unless automatic interrupt mode is chosen, and then writes the dual-page program command.

After the command, it polls the interrupt register until the interrupt bit is seen to go from low to high. It checks the write-interrupt flag and reads the controller status register. From these it classifies the outcome. All device access goes through a single-outstanding request/acknowledge bus with 16-bit address and data. When the operation ends, `done` pulses for one cycle. The 3-bit `result` keeps its value until the next accepted start.

Result codes:
- 0: none
- 1: success
- 2: program error
- 3: lock error
- 4: parameter error
- 5: poll timeout
- 6: write-interrupt missing

Top module: `pgm2x_seq`

## Requirements
- R1: A start with an odd block number (bit 0 of `blk_in` set) makes no bus request. It raises `done` on the next cycle with `result` = 4.
- R2: For an even block, the first three bus writes are sent in this order. First, F100h gets the block number in the low bits and the die select in bit 15. Second, F107h gets the page number in bits 7:2 and zero in bits 1:0. Third, F101h gets the die select in bit 15 and zero elsewhere.
- R3: Next come exactly PAGE_WORDS writes to addresses BUF_BASE+k, for k counting up from 0. Each one carries the k-th word accepted from the stream, and a word is taken only while `s_valid` is high.
- R4: After the data, F200h is written with 0800h. Then F241h is written with 0000h, but only when `auto_int` was low at start. Then F220h is written with 007Dh.
- R5: After the command, the block reads F241h repeatedly. It stops polling only on a reading with bit 15 set that comes after an earlier reading with bit 15 clear. A high reading before any low reading does not end the poll.
- R6: If that ending reading has bit 6 clear, the operation ends with `result` = 6, and F240h is not read.
- R7: Otherwise F240h is read once. Bit 10 clear gives `result` = 1, whatever bit 14 holds. Bit 10 set with bit 14 set gives 3. Bit 10 set with bit 14 clear gives 2.
- R8: If `poll_limit` reads of F241h complete without the rising pattern, the operation ends with `result` = 5 and no further reads. A limit of 0 acts as 1.
- R9: After reset, `done`, `result` and `bus_req` are 0. `done` is high for exactly one cycle per operation. `result` is cleared on an accepted start and otherwise changes only together with `done`.
- R10: Once `bus_req` rises, it stays high with `bus_addr`, `bus_we` and `bus_wdata` unchanged until the cycle in which `bus_ack` is seen. Only one transaction is open at a time. Read data is taken from `bus_rdata` in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted when idle |
| blk_in | input | BLK_W | Target block number |
| page_in | input | PAGE_W | Target page number |
| die_in | input | 1 | Die select |
| auto_int | input | 1 | Automatic interrupt mode: skip the interrupt clear |
| poll_limit | input | CNT_W | Maximum number of interrupt-register reads |
| s_data | input | 16 | Page data stream word |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word taken |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, valid with acknowledge |
| bus_ack | input | 1 | Transaction acknowledge |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Outcome code, held until next start |

## Verification
The bench sweeps die select, interrupt mode and every outcome path. It uses a bus responder whose acknowledge latency varies and a data stream that stalls. Each case compares the whole logged transaction list against one computed in the bench.

Targeted corners:
- A stale high interrupt seen before any low reading. A sequencer that ends polling there would report success after a single read.
- A status word with the lock bit set but the error bit clear. A decoder that tests lock first would report a lock error.
- Interrupt mode. A sequencer that ignores it would write the interrupt clear in both modes, or in neither.
- A poll that never rises, with the limit set to four reads. An off-by-one counter would log three or five reads.
- An odd block. A sequencer that checks the block late would put address writes on the bus before rejecting it.

// File: rtl/pgm2x_pkg.sv
package pgm2x_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BLK,
        ST_PAGE,
        ST_BUFSEL,
        ST_DATA,
        ST_BUFCFG,
        ST_INTCLR,
        ST_CMD,
        ST_POLL,
        ST_STAT
    } seq_state_e;

    typedef enum logic [2:0] {
        RES_NONE    = 3'd0,
        RES_OK      = 3'd1,
        RES_PROG    = 3'd2,
        RES_LOCK    = 3'd3,
        RES_PARAM   = 3'd4,
        RES_TIMEOUT = 3'd5,
        RES_NOWI    = 3'd6
    } seq_result_e;

    localparam logic [15:0] ADDR_BLK    = 16'hF100;
    localparam logic [15:0] ADDR_BUFSEL = 16'hF101;
    localparam logic [15:0] ADDR_PAGE   = 16'hF107;
    localparam logic [15:0] ADDR_BUFCFG = 16'hF200;
    localparam logic [15:0] ADDR_CMD    = 16'hF220;
    localparam logic [15:0] ADDR_STAT   = 16'hF240;
    localparam logic [15:0] ADDR_INT    = 16'hF241;

    localparam logic [15:0] CMD_PGM2X   = 16'h007D;
    localparam logic [15:0] BUFCFG_WORD = 16'h0800;
    localparam logic [15:0] INT_CLEAR   = 16'h0000;

endpackage

// File: rtl/pgm2x_bus_if.sv
module pgm2x_bus_if #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic          we_in,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    output logic          idle,
    output logic          fin,
    output logic [DW-1:0] rd_word,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack
);

    typedef struct packed {
        logic          req;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          fin;
    } bus_regs_t;

    bus_regs_t q, d;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        if (q.req) begin
            if (bus_ack) begin
                d.req   = 1'b0;
                d.fin   = 1'b1;
                d.rdata = bus_rdata;
            end
        end else if (issue) begin
            d.req   = 1'b1;
            d.we    = we_in;
            d.addr  = addr_in;
            d.wdata = wdata_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign idle      = !q.req;
    assign fin       = q.fin;
    assign rd_word   = q.rdata;
    assign bus_req   = q.req;
    assign bus_we    = q.we;
    assign bus_addr  = q.addr;
    assign bus_wdata = q.wdata;

    // R10: an open request holds its fields until acknowledged
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R10: completion pulse follows an acknowledged request
    p_fin_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> (fin && !bus_req));

endmodule

// File: rtl/pgm2x_poll_cnt.sv
module pgm2x_poll_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_regs_t;

    cnt_regs_t q, d;
    logic [CNT_W-1:0] eff_limit;

    assign eff_limit = (limit == '0) ? CNT_W'(1) : limit;
    assign last      = ({1'b0, q.count} + (CNT_W+1)'(1)) >= {1'b0, eff_limit};

    always_comb begin
        d = q;
        if (clr) begin
            d.count = '0;
        end else if (inc) begin
            d.count = q.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R8: the sequencer never counts a read past the limit
    p_no_inc_past_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> (q.count < eff_limit));

endmodule

// File: rtl/pgm2x_stat_decode.sv
module pgm2x_stat_decode #(
    parameter int INT_BIT  = 15,
    parameter int WI_BIT   = 6,
    parameter int ERR_BIT  = 10,
    parameter int LOCK_BIT = 14
) (
    input  logic [15:0] word,
    output logic        int_high,
    output logic        wi_set,
    output logic [2:0]  stat_res
);

    import pgm2x_pkg::*;

    logic word_unused;

    assign word_unused = ^word;
    assign int_high    = word[INT_BIT];
    assign wi_set      = word[WI_BIT];

    always_comb begin
        if (!word[ERR_BIT]) begin
            stat_res = RES_OK;
        end else if (word[LOCK_BIT]) begin
            stat_res = RES_LOCK;
        end else begin
            stat_res = RES_PROG;
        end
    end

endmodule

// File: rtl/pgm2x_seq.sv
module pgm2x_seq #(
    parameter int          BLK_W      = 10,
    parameter int          PAGE_W     = 6,
    parameter int          PAGE_LSB   = 2,
    parameter int          DIE_BIT    = 15,
    parameter int          CNT_W      = 16,
    parameter int          PAGE_WORDS = 1024,
    parameter logic [15:0] BUF_BASE   = 16'h0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BLK_W-1:0]  blk_in,
    input  logic [PAGE_W-1:0] page_in,
    input  logic              die_in,
    input  logic              auto_int,
    input  logic [CNT_W-1:0]  poll_limit,
    input  logic [15:0]       s_data,
    input  logic              s_valid,
    output logic              s_ready,
    output logic              bus_req,
    output logic              bus_we,
    output logic [15:0]       bus_addr,
    output logic [15:0]       bus_wdata,
    input  logic [15:0]       bus_rdata,
    input  logic              bus_ack,
    output logic              done,
    output logic [2:0]        result
);

    import pgm2x_pkg::*;

    localparam int WCNT_W = $clog2(PAGE_WORDS + 1);
    localparam logic [WCNT_W-1:0] WCNT_LAST = WCNT_W'(PAGE_WORDS - 1);

    typedef struct packed {
        seq_state_e        state;
        logic              sent;
        logic [BLK_W-1:0]  blk;
        logic [PAGE_W-1:0] page;
        logic              die;
        logic              auto_m;
        logic              seen_low;
        logic [WCNT_W-1:0] wcnt;
        logic [2:0]        result;
        logic              done;
    } seq_regs_t;

    seq_regs_t q, d;

    logic        issue;
    logic        step_act;
    logic        step_gate;
    logic        step_we;
    logic [15:0] step_addr;
    logic [15:0] step_wdata;
    logic        bus_idle;
    logic        bus_fin;
    logic [15:0] rd_word;
    logic        cnt_clr;
    logic        cnt_inc;
    logic        poll_last;
    logic        int_high;
    logic        wi_set;
    logic [2:0]  stat_res;
    logic [15:0] blk_word;
    logic [15:0] page_word;
    logic [15:0] bufsel_word;

    assign blk_word    = 16'(q.blk) | (16'(q.die) << DIE_BIT);
    assign page_word   = 16'(q.page) << PAGE_LSB;
    assign bufsel_word = 16'(q.die) << DIE_BIT;

    pgm2x_bus_if #(.AW(16), .DW(16)) bus_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .we_in     (step_we),
        .addr_in   (step_addr),
        .wdata_in  (step_wdata),
        .idle      (bus_idle),
        .fin       (bus_fin),
        .rd_word   (rd_word),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack)
    );

    pgm2x_poll_cnt #(.CNT_W(CNT_W)) poll_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .limit (poll_limit),
        .last  (poll_last)
    );

    pgm2x_stat_decode #(
        .INT_BIT  (15),
        .WI_BIT   (6),
        .ERR_BIT  (10),
        .LOCK_BIT (14)
    ) dec_i (
        .word     (rd_word),
        .int_high (int_high),
        .wi_set   (wi_set),
        .stat_res (stat_res)
    );

    // Bus step selected by the current state
    always_comb begin
        step_act   = 1'b1;
        step_gate  = 1'b1;
        step_we    = 1'b1;
        step_addr  = '0;
        step_wdata = '0;
        unique case (q.state)
            ST_BLK: begin
                step_addr  = ADDR_BLK;
                step_wdata = blk_word;
            end
            ST_PAGE: begin
                step_addr  = ADDR_PAGE;
                step_wdata = page_word;
            end
            ST_BUFSEL: begin
                step_addr  = ADDR_BUFSEL;
                step_wdata = bufsel_word;
            end
            ST_DATA: begin
                step_addr  = BUF_BASE + 16'(q.wcnt);
                step_wdata = s_data;
                step_gate  = s_valid;
            end
            ST_BUFCFG: begin
                step_addr  = ADDR_BUFCFG;
                step_wdata = BUFCFG_WORD;
            end
            ST_INTCLR: begin
                step_addr  = ADDR_INT;
                step_wdata = INT_CLEAR;
            end
            ST_CMD: begin
                step_addr  = ADDR_CMD;
                step_wdata = CMD_PGM2X;
            end
            ST_POLL: begin
                step_addr = ADDR_INT;
                step_we   = 1'b0;
            end
            ST_STAT: begin
                step_addr = ADDR_STAT;
                step_we   = 1'b0;
            end
            default: begin
                step_act = 1'b0;
            end
        endcase
    end

    assign issue   = step_act && step_gate && !q.sent && bus_idle;
    assign s_ready = issue && (q.state == ST_DATA);

    // Next-state computation
    always_comb begin
        d       = q;
        d.done  = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;

        if (issue) begin
            d.sent = 1'b1;
        end

        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.blk      = blk_in;
                    d.page     = page_in;
                    d.die      = die_in;
                    d.auto_m   = auto_int;
                    d.seen_low = 1'b0;
                    d.sent     = 1'b0;
                    d.wcnt     = '0;
                    d.result   = RES_NONE;
                    cnt_clr    = 1'b1;
                    if (blk_in[0]) begin
                        d.result = RES_PARAM;
                        d.done   = 1'b1;
                    end else begin
                        d.state = ST_BLK;
                    end
                end
            end
            ST_BLK: begin
                if (bus_fin) begin
                    d.sent  = 1'b0;
                    d.state = ST_PAGE;
                end
            end
            ST_PAGE: begin
                if (bus_fin) begin
                    d.sent  = 1'b0;
                    d.state = ST_BUFSEL;
                end
            end
            ST_BUFSEL: begin
                if (bus_fin) begin
                    d.sent  = 1'b0;
                    d.state = ST_DATA;
                end
            end
            ST_DATA: begin
                if (bus_fin) begin
                    d.sent = 1'b0;
                    d.wcnt = q.wcnt + WCNT_W'(1);
                    if (q.wcnt == WCNT_LAST) begin
                        d.state = ST_BUFCFG;
                    end
                end
            end
            ST_BUFCFG: begin
                if (bus_fin) begin
                    d.sent  = 1'b0;
                    d.state = q.auto_m ? ST_CMD : ST_INTCLR;
                end
            end
            ST_INTCLR: begin
                if (bus_fin) begin
                    d.sent  = 1'b0;
                    d.state = ST_CMD;
                end
            end
            ST_CMD: begin
                if (bus_fin) begin
                    d.sent  = 1'b0;
                    d.state = ST_POLL;
                end
            end
            ST_POLL: begin
                if (bus_fin) begin
                    d.sent  = 1'b0;
                    cnt_inc = 1'b1;
                    if (q.seen_low && int_high) begin
                        if (wi_set) begin
                            d.state = ST_STAT;
                        end else begin
                            d.state  = ST_IDLE;
                            d.result = RES_NOWI;
                            d.done   = 1'b1;
                        end
                    end else begin
                        if (!int_high) begin
                            d.seen_low = 1'b1;
                        end
                        if (poll_last) begin
                            d.state  = ST_IDLE;
                            d.result = RES_TIMEOUT;
                            d.done   = 1'b1;
                        end
                    end
                end
            end
            ST_STAT: begin
                if (bus_fin) begin
                    d.sent   = 1'b0;
                    d.state  = ST_IDLE;
                    d.result = stat_res;
                    d.done   = 1'b1;
                end
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done   = q.done;
    assign result = q.result;

    // R1: odd block rejected at once with no bus traffic
    p_param_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && start && blk_in[0]) |=> (done && result == RES_PARAM && !bus_req));

    // R4: the command address always carries the program command as a write
    p_cmd_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_addr == ADDR_CMD) |-> (bus_we && bus_wdata == CMD_PGM2X));

    // R5: reads only ever target the interrupt or status registers
    p_read_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |-> (bus_addr == ADDR_INT || bus_addr == ADDR_STAT));

    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: result moves only with done or an accepted start
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (done || $stable(result)));

endmodule

// File: tb/pgm2x_seq_tb_top.sv
module pgm2x_seq_tb_top;

    localparam int          BLK_W  = 10;
    localparam int          PAGE_W = 6;
    localparam int          CNT_W  = 8;
    localparam int          WORDS  = 8;
    localparam logic [15:0] BASE   = 16'h0200;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [BLK_W-1:0]  blk_in = '0;
    logic [PAGE_W-1:0] page_in = '0;
    logic              die_in = 1'b0;
    logic              auto_int = 1'b0;
    logic [CNT_W-1:0]  poll_limit = 8'd4;
    logic [15:0]       s_data;
    logic              s_valid;
    logic              s_ready;
    logic              bus_req;
    logic              bus_we;
    logic [15:0]       bus_addr;
    logic [15:0]       bus_wdata;
    logic [15:0]       bus_rdata = '0;
    logic              bus_ack = 1'b0;
    logic              done;
    logic [2:0]        result;

    always #10 clk = ~clk;

    pgm2x_seq #(
        .BLK_W(BLK_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W),
        .PAGE_WORDS(WORDS), .BUF_BASE(BASE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_in(blk_in),
        .page_in(page_in), .die_in(die_in), .auto_int(auto_int),
        .poll_limit(poll_limit), .s_data(s_data), .s_valid(s_valid),
        .s_ready(s_ready), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .done(done), .result(result)
    );

    int checks = 0;
    int bad = 0;

    // Responder, stream source and handshake monitor
    logic [15:0] log_addr [0:63];
    logic [15:0] log_data [0:63];
    logic        log_we   [0:63];
    int          log_n = 0;
    int          int_rd = 0;
    int          lat = 0;
    int          viol = 0;
    logic [15:0] int_seq [0:3];
    int          int_len = 1;
    logic [15:0] stat_val = '0;
    logic        log_clr = 1'b0;
    logic        stall = 1'b0;
    int          cyc = 0;
    int          src_idx = 0;
    logic        p_req = 1'b0, p_ack = 1'b0;
    logic [15:0] p_addr = '0, p_wdata = '0;

    function automatic logic [15:0] word_of(int k);
        return 16'(k * 311) ^ 16'hA55A;
    endfunction

    assign s_valid = stall ? ((cyc % 3) != 2) : 1'b1;
    assign s_data  = word_of(src_idx);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (log_clr) src_idx <= 0;
        else if (s_valid && s_ready) src_idx <= src_idx + 1;
        if (p_req && !p_ack && (!bus_req || bus_addr != p_addr || bus_wdata != p_wdata))
            viol = viol + 1;
        p_req = bus_req; p_ack = bus_ack; p_addr = bus_addr; p_wdata = bus_wdata;
        if (log_clr) begin
            log_n  = 0;
            int_rd = 0;
        end
        if (!rst_n) begin
            bus_ack <= 1'b0;
            lat = 0;
        end else if (bus_req && !bus_ack) begin
            if (lat >= (log_n % 3)) begin
                lat = 0;
                bus_ack <= 1'b1;
                if (log_n < 64) begin
                    log_addr[log_n] = bus_addr;
                    log_data[log_n] = bus_wdata;
                    log_we[log_n]   = bus_we;
                end
                log_n = log_n + 1;
                if (!bus_we) begin
                    if (bus_addr == 16'hF241) begin
                        bus_rdata <= int_seq[(int_rd < int_len) ? int_rd : int_len - 1];
                        int_rd = int_rd + 1;
                    end else if (bus_addr == 16'hF240) begin
                        bus_rdata <= stat_val;
                    end else begin
                        bus_rdata <= 16'hBAD0;
                    end
                end
            end else begin
                lat = lat + 1;
            end
        end else begin
            bus_ack <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    logic [15:0] e_addr [0:63];
    logic [15:0] e_data [0:63];
    logic        e_we   [0:63];
    string       e_tag  [0:63];

    task automatic run_case(input int blk, input int page, input bit die,
                            input bit aut, input int scen, input bit stl);
        int    n_exp = 0;
        int    reads = 0;
        bit    rd_stat = 1'b0;
        int    exp_res;
        string rtag;
        int    n;
        int    held;
        case (scen)
            0: begin int_seq[0]=16'h0000; int_seq[1]=16'h0000; int_seq[2]=16'h8040; int_len=3;
                     stat_val=16'h0000; reads=3; rd_stat=1; exp_res=1; rtag="R7"; end
            1: begin int_seq[0]=16'h0000; int_seq[1]=16'h8040; int_len=2;
                     stat_val=16'h0400; reads=2; rd_stat=1; exp_res=2; rtag="R7"; end
            2: begin int_seq[0]=16'h0000; int_seq[1]=16'h8040; int_len=2;
                     stat_val=16'h4400; reads=2; rd_stat=1; exp_res=3; rtag="R7"; end
            3: begin int_seq[0]=16'h0000; int_seq[1]=16'h8000; int_len=2;
                     stat_val=16'h0000; reads=2; rd_stat=0; exp_res=6; rtag="R6"; end
            4: begin int_seq[0]=16'h0000; int_len=1;
                     stat_val=16'h0000; reads=4; rd_stat=0; exp_res=5; rtag="R8"; end
            5: begin int_seq[0]=16'h8040; int_seq[1]=16'h0000; int_seq[2]=16'h8040; int_len=3;
                     stat_val=16'h0000; reads=3; rd_stat=1; exp_res=1; rtag="R5"; end
            default: begin int_seq[0]=16'h0000; int_seq[1]=16'h8040; int_len=2;
                     stat_val=16'h4000; reads=2; rd_stat=1; exp_res=1; rtag="R7"; end
        endcase
        if ((blk % 2) == 1) begin
            exp_res = 4; rtag = "R1";
        end else begin
            e_addr[0]=16'hF100; e_data[0]=16'(blk) | (die ? 16'h8000 : 16'h0); e_we[0]=1; e_tag[0]="R2";
            e_addr[1]=16'hF107; e_data[1]=16'(page * 4); e_we[1]=1; e_tag[1]="R2";
            e_addr[2]=16'hF101; e_data[2]=die ? 16'h8000 : 16'h0; e_we[2]=1; e_tag[2]="R2";
            n_exp = 3;
            for (int k = 0; k < WORDS; k++) begin
                e_addr[n_exp]=BASE + 16'(k); e_data[n_exp]=word_of(k); e_we[n_exp]=1; e_tag[n_exp]="R3";
                n_exp++;
            end
            e_addr[n_exp]=16'hF200; e_data[n_exp]=16'h0800; e_we[n_exp]=1; e_tag[n_exp]="R4"; n_exp++;
            if (!aut) begin
                e_addr[n_exp]=16'hF241; e_data[n_exp]=16'h0000; e_we[n_exp]=1; e_tag[n_exp]="R4"; n_exp++;
            end
            e_addr[n_exp]=16'hF220; e_data[n_exp]=16'h007D; e_we[n_exp]=1; e_tag[n_exp]="R4"; n_exp++;
            for (int k = 0; k < reads; k++) begin
                e_addr[n_exp]=16'hF241; e_data[n_exp]=16'h0; e_we[n_exp]=0; e_tag[n_exp]=rtag; n_exp++;
            end
            if (rd_stat) begin
                e_addr[n_exp]=16'hF240; e_data[n_exp]=16'h0; e_we[n_exp]=0; e_tag[n_exp]="R7"; n_exp++;
            end
        end

        @(negedge clk);
        log_clr = 1'b1;
        stall   = stl;
        blk_in  = BLK_W'(blk);
        page_in = PAGE_W'(page);
        die_in  = die;
        auto_int = aut;
        @(negedge clk);
        log_clr = 1'b0;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, "R9", "done seen", int'(done), 1);
        check(int'(result) == exp_res, rtag, "result code", int'(result), exp_res);
        check(log_n == n_exp, (n_exp == 0) ? "R1" : "R4", "transaction count", log_n, n_exp);
        for (int i = 0; i < n_exp && i < log_n && i < 64; i++) begin
            check(log_addr[i] == e_addr[i] && log_we[i] == e_we[i] &&
                  (!e_we[i] || log_data[i] == e_data[i]),
                  e_tag[i], $sformatf("entry %0d addr/data", i),
                  int'({log_addr[i], log_data[i]}), int'({e_addr[i], e_data[i]}));
        end
        @(negedge clk);
        check(done == 1'b0, "R9", "done pulse width", int'(done), 0);
        held = int'(result);
        repeat (3) @(negedge clk);
        check(int'(result) == exp_res && held == exp_res, "R9", "result held",
              int'(result), exp_res);
    endtask

    initial begin
        #(200000 * 20);
        bad++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R9", "reset done", int'(done), 0);
        check(result == 3'd0, "R9", "reset result", int'(result), 0);
        check(bus_req == 1'b0, "R9", "reset bus_req", int'(bus_req), 0);
        check(s_ready == 1'b0, "R3", "reset s_ready", int'(s_ready), 0);

        for (int dv = 0; dv < 2; dv++) begin
            for (int av = 0; av < 2; av++) begin
                for (int sc = 0; sc < 7; sc++) begin
                    run_case(((dv * 2 + av) * 100 + sc * 2) % 1024, (sc * 9 + dv) % 64,
                             dv[0], av[0], sc, sc[0]);
                end
            end
        end
        run_case(1, 5, 1'b0, 1'b0, 0, 1'b0);
        run_case(3, 0, 1'b1, 1'b1, 1, 1'b1);
        run_case(1023, 63, 1'b1, 1'b0, 2, 1'b0);

        check(viol == 0, "R10", "request held until ack", viol, 0);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule